// File: doc/BRIEF.md
# Test Access Port Controller State Machine

This block is the sequencing core of a boundary-scan test port. It steps through a fixed graph of sixteen states, advancing on each rising edge of the test clock `tck`. The single steering input `tms` picks which way to go. From the current state it produces the strobes that drive an external instruction register and the generic data registers: a clock enable, a shift strobe and an update strobe for each. It also produces a test-logic reset, a select that steers the serial output towards the instruction path, and an output-driver enable.

All control outputs are registered on the falling edge of `tck`. They therefore settle half a cycle after the state moves and stay steady across the next rising edge, where the registers sample them. An active-low `trst_n` returns the machine and its outputs to the reset state at once, without a clock. The instruction and data registers themselves, and the decoding of instructions, lie outside this block.

The state code is brought out on `state_o`:

| Code | State | tms=0 goes to | tms=1 goes to |
|---|---|---|---|
| 0 | TEST_RESET | RUN_IDLE | TEST_RESET |
| 1 | RUN_IDLE | RUN_IDLE | SEL_DR |
| 2 | SEL_DR | CAP_DR | SEL_IR |
| 3 | CAP_DR | SH_DR | EX1_DR |
| 4 | SH_DR | SH_DR | EX1_DR |
| 5 | EX1_DR | PAU_DR | UPD_DR |
| 6 | PAU_DR | PAU_DR | EX2_DR |
| 7 | EX2_DR | SH_DR | UPD_DR |
| 8 | UPD_DR | RUN_IDLE | SEL_DR |
| 9 | SEL_IR | CAP_IR | TEST_RESET |
| 10 | CAP_IR | SH_IR | EX1_IR |
| 11 | SH_IR | SH_IR | EX1_IR |
| 12 | EX1_IR | PAU_IR | UPD_IR |
| 13 | PAU_IR | PAU_IR | EX2_IR |
| 14 | EX2_IR | SH_IR | UPD_IR |
| 15 | UPD_IR | RUN_IDLE | SEL_DR |

Top module: `tap_fsm_ctrl`

## Requirements
- R1: The state register holds one of the sixteen 4-bit codes of the table above. On each rising `tck` edge it moves to the entry of the table chosen by the sampled `tms`, and to no other state.
- R2: `state_o` changes only at a rising `tck` edge. Every control output changes only at a falling `tck` edge, so just after a rising edge the outputs still show the values decoded from the previous state.
- R3: While `trst_n` is 0, `state_o` is 0 (TEST_RESET). `rst_o` is 1 and all other control outputs are 0, taking effect immediately without any `tck` edge.
- R4: From any state, five consecutive rising edges with `tms`=1 leave the machine in TEST_RESET.
- R5: SH_DR and SH_IR are held while `tms` is 0. EX2_DR and EX2_IR return to their own shift state when `tms` is 0.
- R6: After each falling edge: `rst_o` is 1 exactly when the state is TEST_RESET. `dr_shift_o`/`ir_shift_o` are 1 exactly in SH_DR/SH_IR. `dr_update_o`/`ir_update_o` are 1 exactly in UPD_DR/UPD_IR. At most one of these five is 1.
- R7: `tdo_en_o` is 1 only while the state is SH_DR or SH_IR.
- R8: `sel_ir_o` is 1 exactly in the seven states SEL_IR to UPD_IR (codes 9 to 15). `dr_clk_en_o` is 1 exactly in CAP_DR and SH_DR, and `ir_clk_en_o` is 1 exactly in CAP_IR and SH_IR.
- R9: TEST_RESET is held while `tms` is 1, and RUN_IDLE is held while `tms` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; state moves on rising edge, outputs on falling edge |
| trst_n | input | 1 | Asynchronous active-low return to TEST_RESET |
| tms | input | 1 | Path select sampled on rising `tck` |
| state_o | output | 4 | Current state code (table above) |
| rst_o | output | 1 | Test logic reset, high in TEST_RESET |
| sel_ir_o | output | 1 | Serial output source select, high for instruction path |
| tdo_en_o | output | 1 | Serial output driver enable |
| ir_clk_en_o | output | 1 | Instruction register clock enable (capture or shift) |
| ir_shift_o | output | 1 | Instruction register shift strobe |
| ir_update_o | output | 1 | Instruction register update strobe |
| dr_clk_en_o | output | 1 | Data register clock enable (capture or shift) |
| dr_shift_o | output | 1 | Data register shift strobe |
| dr_update_o | output | 1 | Data register update strobe |

## Verification
Every cycle, the assertions watch several invariants. A run of five `tms` ones must have reached TEST_RESET. The shift states and TEST_RESET must hold under their holding input. The driver enable and the instruction select must appear only in their legal states, and the shift, update and reset strobes must stay mutually exclusive. The bench alone covers the rest. It walks each of the 32 arcs from a known start, and it sends five ones from every one of the sixteen states. It observes the half-cycle offset between state and outputs at both clock edges. It also pulls `trst_n` low in the middle of a shift, where only timing between edges can expose the asynchronous return.

// File: rtl/tap_fsm_pkg.sv
package tap_fsm_pkg;

    localparam int TAP_STW = 4;

    typedef enum logic [TAP_STW-1:0] {
        TEST_RESET = 4'd0,
        RUN_IDLE   = 4'd1,
        SEL_DR     = 4'd2,
        CAP_DR     = 4'd3,
        SH_DR      = 4'd4,
        EX1_DR     = 4'd5,
        PAU_DR     = 4'd6,
        EX2_DR     = 4'd7,
        UPD_DR     = 4'd8,
        SEL_IR     = 4'd9,
        CAP_IR     = 4'd10,
        SH_IR      = 4'd11,
        EX1_IR     = 4'd12,
        PAU_IR     = 4'd13,
        EX2_IR     = 4'd14,
        UPD_IR     = 4'd15
    } tap_state_e;

    typedef struct packed {
        logic rst;
        logic sel_ir;
        logic tdo_en;
        logic ir_clk_en;
        logic ir_shift;
        logic ir_update;
        logic dr_clk_en;
        logic dr_shift;
        logic dr_update;
    } tap_ctl_t;

    localparam tap_ctl_t TAP_CTL_RESET = '{rst: 1'b1, default: 1'b0};

endpackage

// File: rtl/tap_next_state.sv
module tap_next_state
    import tap_fsm_pkg::*;
(
    input  tap_state_e cur,
    input  logic       tms,
    output tap_state_e nxt
);

    always_comb begin
        unique case (cur)
            TEST_RESET: nxt = tms ? TEST_RESET : RUN_IDLE;
            RUN_IDLE:   nxt = tms ? SEL_DR     : RUN_IDLE;
            SEL_DR:     nxt = tms ? SEL_IR     : CAP_DR;
            CAP_DR:     nxt = tms ? EX1_DR     : SH_DR;
            SH_DR:      nxt = tms ? EX1_DR     : SH_DR;
            EX1_DR:     nxt = tms ? UPD_DR     : PAU_DR;
            PAU_DR:     nxt = tms ? EX2_DR     : PAU_DR;
            EX2_DR:     nxt = tms ? UPD_DR     : SH_DR;
            UPD_DR:     nxt = tms ? SEL_DR     : RUN_IDLE;
            SEL_IR:     nxt = tms ? TEST_RESET : CAP_IR;
            CAP_IR:     nxt = tms ? EX1_IR     : SH_IR;
            SH_IR:      nxt = tms ? EX1_IR     : SH_IR;
            EX1_IR:     nxt = tms ? UPD_IR     : PAU_IR;
            PAU_IR:     nxt = tms ? EX2_IR     : PAU_IR;
            EX2_IR:     nxt = tms ? UPD_IR     : SH_IR;
            UPD_IR:     nxt = tms ? SEL_DR     : RUN_IDLE;
            default:    nxt = TEST_RESET;
        endcase
    end

endmodule

// File: rtl/tap_state_reg.sv
module tap_state_reg
    import tap_fsm_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  tap_state_e nxt,
    output tap_state_e cur
);

    localparam int RW = $clog2(RESET_RUN + 1);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) cur <= TEST_RESET;
        else         cur <= nxt;
    end

    // Checker state: length of the current run of tms ones, saturating
    logic [RW-1:0] ones_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                               ones_run <= '0;
        else if (!tms)                             ones_run <= '0;
        else if (ones_run != RW'(RESET_RUN))       ones_run <= ones_run + 1'b1;
    end

    p_five_ones_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == RW'(RESET_RUN)) |-> (cur == TEST_RESET));

    p_reset_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (cur == TEST_RESET && tms) |=> (cur == TEST_RESET));

    p_idle_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (cur == RUN_IDLE && !tms) |=> (cur == RUN_IDLE));

    p_shift_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        ((cur == SH_DR || cur == SH_IR) && !tms) |=> (cur == $past(cur)));

    p_exit2_back_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (cur == EX2_DR && !tms) |=> (cur == SH_DR));

endmodule

// File: rtl/tap_out_gen.sv
module tap_out_gen
    import tap_fsm_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e cur,
    output tap_ctl_t   ctl
);

    tap_ctl_t dec;

    always_comb begin
        dec           = '0;
        dec.rst       = (cur == TEST_RESET);
        dec.sel_ir    = (cur >= SEL_IR);
        dec.tdo_en    = (cur == SH_DR) || (cur == SH_IR);
        dec.ir_clk_en = (cur == CAP_IR) || (cur == SH_IR);
        dec.ir_shift  = (cur == SH_IR);
        dec.ir_update = (cur == UPD_IR);
        dec.dr_clk_en = (cur == CAP_DR) || (cur == SH_DR);
        dec.dr_shift  = (cur == SH_DR);
        dec.dr_update = (cur == UPD_DR);
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) ctl <= TAP_CTL_RESET;
        else         ctl <= dec;
    end

    // Sampled at rising edge: outputs reflect the state held since the last rise
    p_tdo_en_shift_r7: assert property (@(posedge tck) disable iff (!trst_n)
        ctl.tdo_en |-> (cur == SH_DR || cur == SH_IR));

    p_strobe_onehot_r6: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({ctl.rst, ctl.ir_shift, ctl.ir_update, ctl.dr_shift, ctl.dr_update}));

    p_dr_shift_state_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (cur == SH_DR) |-> ctl.dr_shift);

    p_sel_ir_branch_r8: assert property (@(posedge tck) disable iff (!trst_n)
        ctl.sel_ir |-> (cur >= SEL_IR));

endmodule

// File: rtl/tap_fsm_ctrl.sv
module tap_fsm_ctrl
    import tap_fsm_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output logic [3:0] state_o,
    output logic       rst_o,
    output logic       sel_ir_o,
    output logic       tdo_en_o,
    output logic       ir_clk_en_o,
    output logic       ir_shift_o,
    output logic       ir_update_o,
    output logic       dr_clk_en_o,
    output logic       dr_shift_o,
    output logic       dr_update_o
);

    tap_state_e cur;
    tap_state_e nxt;
    tap_ctl_t   ctl;

    tap_next_state u_next (
        .cur (cur),
        .tms (tms),
        .nxt (nxt)
    );

    tap_state_reg #(.RESET_RUN(5)) u_state (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .nxt    (nxt),
        .cur    (cur)
    );

    tap_out_gen u_out (
        .tck    (tck),
        .trst_n (trst_n),
        .cur    (cur),
        .ctl    (ctl)
    );

    assign state_o     = cur;
    assign rst_o       = ctl.rst;
    assign sel_ir_o    = ctl.sel_ir;
    assign tdo_en_o    = ctl.tdo_en;
    assign ir_clk_en_o = ctl.ir_clk_en;
    assign ir_shift_o  = ctl.ir_shift;
    assign ir_update_o = ctl.ir_update;
    assign dr_clk_en_o = ctl.dr_clk_en;
    assign dr_shift_o  = ctl.dr_shift;
    assign dr_update_o = ctl.dr_update;

endmodule

// File: tb/tb_tap_fsm_ctrl.sv
`timescale 1ns/1ps
module tb_tap_fsm_ctrl;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic [3:0] state_o;
    logic rst_o, sel_ir_o, tdo_en_o, ir_clk_en_o, ir_shift_o, ir_update_o;
    logic dr_clk_en_o, dr_shift_o, dr_update_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 tck = ~tck;   // 250 MHz

    tap_fsm_ctrl dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
        .rst_o(rst_o), .sel_ir_o(sel_ir_o), .tdo_en_o(tdo_en_o),
        .ir_clk_en_o(ir_clk_en_o), .ir_shift_o(ir_shift_o), .ir_update_o(ir_update_o),
        .dr_clk_en_o(dr_clk_en_o), .dr_shift_o(dr_shift_o), .dr_update_o(dr_update_o)
    );

    // Observed control word: {rst, sel_ir, tdo_en, ir_clk, ir_shift, ir_upd, dr_clk, dr_shift, dr_upd}
    function automatic logic [8:0] ctl_now();
        return {rst_o, sel_ir_o, tdo_en_o, ir_clk_en_o, ir_shift_o, ir_update_o,
                dr_clk_en_o, dr_shift_o, dr_update_o};
    endfunction

    // Reference graph from the R1 table
    function automatic logic [3:0] model_next(input logic [3:0] s, input logic b);
        case (s)
            4'd0:  return b ? 4'd0  : 4'd1;
            4'd1:  return b ? 4'd2  : 4'd1;
            4'd2:  return b ? 4'd9  : 4'd3;
            4'd3:  return b ? 4'd5  : 4'd4;
            4'd4:  return b ? 4'd5  : 4'd4;
            4'd5:  return b ? 4'd8  : 4'd6;
            4'd6:  return b ? 4'd7  : 4'd6;
            4'd7:  return b ? 4'd8  : 4'd4;
            4'd8:  return b ? 4'd2  : 4'd1;
            4'd9:  return b ? 4'd0  : 4'd10;
            4'd10: return b ? 4'd12 : 4'd11;
            4'd11: return b ? 4'd12 : 4'd11;
            4'd12: return b ? 4'd15 : 4'd13;
            4'd13: return b ? 4'd14 : 4'd13;
            4'd14: return b ? 4'd15 : 4'd11;
            default: return b ? 4'd2 : 4'd1;
        endcase
    endfunction

    // Expected outputs per R6, R7, R8
    function automatic logic [8:0] model_ctl(input logic [3:0] s);
        logic [8:0] c;
        c[8] = (s == 4'd0);
        c[7] = (s >= 4'd9);
        c[6] = (s == 4'd4) || (s == 4'd11);
        c[5] = (s == 4'd10) || (s == 4'd11);
        c[4] = (s == 4'd11);
        c[3] = (s == 4'd15);
        c[2] = (s == 4'd3) || (s == 4'd4);
        c[1] = (s == 4'd4);
        c[0] = (s == 4'd8);
        return c;
    endfunction

    // Path from TEST_RESET: {length, bits first-first}
    function automatic logic [9:0] path_of(input logic [3:0] s);
        case (s)
            4'd0:  return {3'd0, 7'b0000000};
            4'd1:  return {3'd1, 7'b0000000};
            4'd2:  return {3'd2, 7'b0000010};
            4'd3:  return {3'd3, 7'b0000010};
            4'd4:  return {3'd4, 7'b0000010};
            4'd5:  return {3'd4, 7'b0001010};
            4'd6:  return {3'd5, 7'b0001010};
            4'd7:  return {3'd6, 7'b0101010};
            4'd8:  return {3'd5, 7'b0011010};
            4'd9:  return {3'd3, 7'b0000110};
            4'd10: return {3'd4, 7'b0000110};
            4'd11: return {3'd5, 7'b0000110};
            4'd12: return {3'd5, 7'b0010110};
            4'd13: return {3'd6, 7'b0010110};
            4'd14: return {3'd7, 7'b1010110};
            default: return {3'd6, 7'b0110110};
        endcase
    endfunction

    // Scoreboard queues
    string      tag_q[$];
    logic [3:0] st_q[$];
    logic [8:0] ctl_q[$];

    logic [3:0] exp_st;
    logic [8:0] prev_ctl;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Monitor: compares after each falling edge
    initial begin
        forever begin
            @(negedge tck);
            #0.5;
            if (tag_q.size() > 0) begin
                string t;
                logic [3:0] es;
                logic [8:0] ec;
                t  = tag_q.pop_front();
                es = st_q.pop_front();
                ec = ctl_q.pop_front();
                check(state_o == es, {t, " state"}, int'(state_o), int'(es));
                check(ctl_now() == ec, {t, " R6 R7 R8 outputs"}, int'(ctl_now()), int'(ec));
            end
        end
    end

    // Driver: called just after a falling edge
    task automatic step(input logic b, input string tag);
        exp_st = model_next(exp_st, b);
        tms = b;
        tag_q.push_back(tag);
        st_q.push_back(exp_st);
        ctl_q.push_back(model_ctl(exp_st));
        @(posedge tck);
        #1;
        check(state_o == exp_st, "R2 state at rise", int'(state_o), int'(exp_st));
        check(ctl_now() == prev_ctl, "R2 outputs held at rise", int'(ctl_now()), int'(prev_ctl));
        prev_ctl = model_ctl(exp_st);
        @(negedge tck);
        #1;
    endtask

    task automatic goto_state(input logic [3:0] s);
        logic [9:0] p;
        for (int i = 0; i < 5; i++) step(1'b1, "R4 walk to reset");
        p = path_of(s);
        for (int i = 0; i < int'(p[9:7]); i++) step(p[i], "R1 path");
    endtask

    function automatic string arc_tag(input logic [3:0] s, input logic b);
        if ((s == 4'd4 || s == 4'd11) && !b) return "R5 shift hold";
        if ((s == 4'd7 || s == 4'd14) && !b) return "R5 exit2 to shift";
        if ((s == 4'd0 && b) || (s == 4'd1 && !b)) return "R9 hold";
        return "R1 arc";
    endfunction

    initial begin
        #9;
        @(negedge tck);
        #1;
        check(state_o == 4'd0, "R3 state in reset", int'(state_o), 0);
        check(ctl_now() == model_ctl(4'd0), "R3 outputs in reset", int'(ctl_now()), int'(model_ctl(4'd0)));
        trst_n   = 1'b1;
        exp_st   = 4'd0;
        prev_ctl = model_ctl(4'd0);
        @(negedge tck);
        #1;

        // Every arc of the graph
        for (int s = 0; s < 16; s++) begin
            for (int b = 0; b < 2; b++) begin
                goto_state(4'(s));
                step(b[0], arc_tag(4'(s), b[0]));
            end
        end

        // Five ones from every state
        for (int s = 0; s < 16; s++) begin
            goto_state(4'(s));
            for (int i = 0; i < 5; i++) step(1'b1, "R4 five ones");
            check(state_o == 4'd0, "R4 reached reset", int'(state_o), 0);
        end

        // Long shift holds on both branches
        goto_state(4'd4);
        for (int i = 0; i < 6; i++) step(1'b0, "R5 long DR shift");
        check(tdo_en_o == 1'b1, "R7 driver on in DR shift", int'(tdo_en_o), 1);
        goto_state(4'd11);
        for (int i = 0; i < 6; i++) step(1'b0, "R5 long IR shift");
        check(sel_ir_o == 1'b1, "R8 IR select in IR shift", int'(sel_ir_o), 1);

        // Asynchronous reset in the middle of a DR shift
        goto_state(4'd4);
        #0.5;
        trst_n = 1'b0;
        #0.2;
        check(state_o == 4'd0, "R3 async state", int'(state_o), 0);
        check(ctl_now() == model_ctl(4'd0), "R3 async outputs", int'(ctl_now()), int'(model_ctl(4'd0)));
        @(negedge tck);
        #1;
        trst_n   = 1'b1;
        exp_st   = 4'd0;
        prev_ctl = model_ctl(4'd0);
        step(1'b0, "R3 resume after reset");

        @(negedge tck);
        #1;
        check(tag_q.size() == 0, "scoreboard drained", tag_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule